// File: doc/BRIEF.md
# Second-Tick Countdown Alarm

This block is a relative alarm timer that sits beside a calendar clock. Software does not program an absolute time. It loads the gap until the alarm as a packed count of days, hours, minutes and seconds. Every second tick lowers that count by one, in mixed radix, for as long as the counter is switched on.

When a running count arrives at zero, the block raises a pending flag and leaves the count parked at zero. An interrupt line reports the pending flag only while interrupts are unmasked. The line stays high until software clears the flag by writing a one to it.

Four word registers sit on a simple write port and a combinational read port. Software can also disarm the block by writing zero to them. A zero count never fires, so writing zero to the count, the run control and the interrupt mask leaves the block silent.

Top module: `cdal_top`

## Requirements
- R1: After a synchronous active-low reset, all four registers read 0 and `irq` is low.
- R2: The count register at offset 0x0C holds seconds in bits 5:0, minutes in bits 13:8, hours in bits 20:16 and days in bits 28:21 (0 to 255). It reads back exactly what was written in those fields, and every other bit reads 0.
- R3: While the run bit (bit 8 of offset 0x14) is 1 and the count is non-zero, each cycle with `sec_tick` high lowers the count by exactly one second. Cycles without a tick leave the count unchanged.
- R4: A seconds field of 0 becomes 59 and borrows one minute. A minutes field of 0 becomes 59 and borrows one hour. An hours field of 0 becomes 23 and borrows one day.
- R5: The tick that brings a running count to zero sets the pending flag (bit 0 of offset 0x1C). Later ticks leave the count at zero.
- R6: Writing 1 to bit 0 of offset 0x1C clears the pending flag. Writing 0 there leaves the flag unchanged.
- R7: `irq` is high exactly when the pending flag is set and the interrupt mask bit (bit 0 of offset 0x18) is 1. Clearing the mask drops `irq` but keeps the flag.
- R8: While the run bit is 0, ticks change neither the count nor the pending flag.
- R9: A write to the count register takes effect in the following cycle even while the counter is running. A loaded zero never sets the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Read data for `rd_addr`, combinational |
| irq | output | 1 | Alarm interrupt |

## Verification
The countdown is tried with several kinds of gap:
- Plain seconds-only gaps check the single-step decrement and the firing tick.
- Gaps with zero lower fields force each borrow, from seconds up to days. These are the only inputs that separate a correct radix wrap from a plain binary decrement.
- A gap of just over an hour runs to the end against a model that converts the count to total seconds.
- Reloads in mid-count and loads of zero separate reload priority from ticking, and show that a zero count never fires.
- Ticks with the run bit cleared, and writes of 0 and then 1 to the status bit, separate stopping from firing and masking from clearing.

// File: rtl/cdal_pkg.sv
// Shared widths, register offsets and the packed countdown type.
// Assumes word-aligned byte offsets on an 8-bit address.
package cdal_pkg;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int SEC_W    = 6;
    localparam int MIN_W    = 6;
    localparam int HR_W     = 5;
    localparam int DAY_W    = 8;
    localparam int SEC_LSB  = 0;
    localparam int MIN_LSB  = 8;
    localparam int HR_LSB   = 16;
    localparam int DAY_LSB  = 21;
    localparam int SEC_WRAP = 59;
    localparam int MIN_WRAP = 59;
    localparam int HR_WRAP  = 23;
    localparam int DAY_WRAP = (1 << DAY_W) - 1;
    localparam int RUN_BIT  = 8;
    localparam int MASK_BIT = 0;
    localparam int PEND_BIT = 0;

    localparam logic [ADDR_W-1:0] OFS_COUNT  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_RUN    = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h1C;

    typedef struct packed {
        logic [DAY_W-1:0] day;
        logic [HR_W-1:0]  hr;
        logic [MIN_W-1:0] min;
        logic [SEC_W-1:0] sec;
    } gap_t;
endpackage

// File: rtl/cdal_digit.sv
// One radix digit of the countdown. It holds its value, takes a load,
// and on a borrow-in either decrements or wraps to WRAP and borrows out.
// Assumes that load has priority over borrow-in.
module cdal_digit #(
    parameter int W    = 6,
    parameter int WRAP = 59
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         borrow_in,
    output logic [W-1:0] value,
    output logic         borrow_out,
    output logic         next_zero
);
    logic [W-1:0] nxt;

    // Next value and borrow for one decrement request.
    always_comb begin
        nxt        = value;
        borrow_out = 1'b0;
        if (borrow_in) begin
            if (value == '0) begin
                nxt        = W'(WRAP);
                borrow_out = 1'b1;
            end else begin
                nxt = value - 1'b1;
            end
        end
    end

    assign next_zero = (nxt == '0);

    // Digit storage with load priority.
    always_ff @(posedge clk) begin
        if (!rst_n)       value <= '0;
        else if (load)    value <= load_val;
        else              value <= nxt;
    end
endmodule

// File: rtl/cdal_counter.sv
// Mixed-radix day/hour/minute/second countdown. It steps on a tick while
// running and non-zero, and flags the step that lands on zero.
// Assumes a tick lasts one cycle and that a load wins over a tick.
module cdal_counter
    import cdal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run,
    input  logic load,
    input  gap_t load_gap,
    output gap_t gap,
    output logic fire
);
    logic step;
    logic b_sec, b_min, b_hr, b_day;
    logic z_sec, z_min, z_hr, z_day;

    assign step = tick && run && !load && (gap != '0);

    cdal_digit #(.W(SEC_W), .WRAP(SEC_WRAP)) u_sec (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_gap.sec),
        .borrow_in(step), .value(gap.sec), .borrow_out(b_sec), .next_zero(z_sec));
    cdal_digit #(.W(MIN_W), .WRAP(MIN_WRAP)) u_min (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_gap.min),
        .borrow_in(b_sec), .value(gap.min), .borrow_out(b_min), .next_zero(z_min));
    cdal_digit #(.W(HR_W), .WRAP(HR_WRAP)) u_hr (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_gap.hr),
        .borrow_in(b_min), .value(gap.hr), .borrow_out(b_hr), .next_zero(z_hr));
    cdal_digit #(.W(DAY_W), .WRAP(DAY_WRAP)) u_day (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_gap.day),
        .borrow_in(b_hr), .value(gap.day), .borrow_out(b_day), .next_zero(z_day));

    // Flag the step whose result is all zeros.
    always_comb fire = step && z_sec && z_min && z_hr && z_day;

    // R4: a non-zero count never borrows past the day field.
    a_r4_no_day_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        !b_day);
    // R3: without a tick or a load the count holds.
    a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(gap));
    // R8: a stopped counter holds.
    a_r8_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(gap));
    // R5: zero stays zero until reloaded.
    a_r5_zero_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (gap == '0 && !load) |=> (gap == '0));
endmodule

// File: rtl/cdal_regs.sv
// Register file: count load decode, run bit, interrupt mask, a
// write-one-to-clear pending flag, and the read multiplexer.
// Assumes single-cycle writes. A fire in the same cycle as a clear wins.
module cdal_regs
    import cdal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  gap_t              gap,
    input  logic              fire,
    output logic              load,
    output gap_t              load_gap,
    output logic              run,
    output logic              irq_mask,
    output logic              pending,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] wr_data_unused;
    logic              clear;

    assign wr_data_unused = wr_data;

    // Write decode and unpacking of the count fields.
    always_comb begin
        load         = wr_en && (wr_addr == OFS_COUNT);
        clear        = wr_en && (wr_addr == OFS_STATUS) && wr_data[PEND_BIT];
        load_gap.sec = wr_data[SEC_LSB +: SEC_W];
        load_gap.min = wr_data[MIN_LSB +: MIN_W];
        load_gap.hr  = wr_data[HR_LSB  +: HR_W];
        load_gap.day = wr_data[DAY_LSB +: DAY_W];
    end

    // Run and mask control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run      <= 1'b0;
            irq_mask <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == OFS_RUN)  run      <= wr_data[RUN_BIT];
            if (wr_addr == OFS_MASK) irq_mask <= wr_data[MASK_BIT];
        end
    end

    // Pending flag: set by fire, cleared by a write of one.
    always_ff @(posedge clk) begin
        if (!rst_n)     pending <= 1'b0;
        else if (fire)  pending <= 1'b1;
        else if (clear) pending <= 1'b0;
    end

    // Read multiplexer. Unused bits read as zero.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            OFS_COUNT: begin
                rd_data[SEC_LSB +: SEC_W] = gap.sec;
                rd_data[MIN_LSB +: MIN_W] = gap.min;
                rd_data[HR_LSB  +: HR_W]  = gap.hr;
                rd_data[DAY_LSB +: DAY_W] = gap.day;
            end
            OFS_RUN:    rd_data[RUN_BIT]  = run;
            OFS_MASK:   rd_data[MASK_BIT] = irq_mask;
            OFS_STATUS: rd_data[PEND_BIT] = pending;
            default:    rd_data = '0;
        endcase
    end

    // R5: the flag rises only after a firing step.
    a_r5_set_by_fire: assert property (@(posedge clk) disable iff (!rst_n)
        !pending |=> (!pending || $past(fire)));
    // R6: a clear without a coincident fire drops the flag.
    a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !fire) |=> !pending);
    // R6: without a clear the flag holds.
    a_r6_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !clear) |=> pending);
endmodule

// File: rtl/cdal_top.sv
// Countdown alarm top: the register file plus the mixed-radix counter.
// The interrupt is the pending flag gated by the mask.
// Assumes sec_tick is synchronous to clk and lasts one cycle.
module cdal_top
    import cdal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    gap_t gap, load_gap;
    logic load, fire, run, irq_mask, pending;

    cdal_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .gap(gap), .fire(fire),
        .load(load), .load_gap(load_gap), .run(run), .irq_mask(irq_mask),
        .pending(pending), .rd_data(rd_data));

    cdal_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(sec_tick), .run(run), .load(load),
        .load_gap(load_gap), .gap(gap), .fire(fire));

    // Interrupt gating.
    always_comb irq = pending && irq_mask;

    // R8: a stopped counter never fires.
    a_r8_no_fire_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !fire);
    // R9: a load is never also a firing step.
    a_r9_load_no_fire: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !fire);
endmodule

// File: tb/tb_cdal_top.sv
`timescale 1ns/1ps
module tb_cdal_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq;

    localparam logic [7:0] A_CNT = 8'h0C, A_RUN = 8'h14, A_MSK = 8'h18,
                           A_STS = 8'h1C, A_PIN = 8'hFF;

    cdal_top dut (.clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq(irq));

    always #5 clk = ~clk;

    typedef struct {
        logic [7:0]  addr;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sbq[$];
    int    checks = 0, failures = 0, issued = 0, served = 0;
    bit    finished = 0;

    function automatic logic [31:0] pack(int d, int h, int m, int s);
        return (32'(d) << 21) | (32'(h) << 16) | (32'(m) << 8) | 32'(s);
    endfunction

    function automatic int to_secs(logic [31:0] w);
        return ((int'(w[28:21]) * 24 + int'(w[20:16])) * 60 + int'(w[13:8])) * 60
               + int'(w[5:0]);
    endfunction

    function automatic logic [31:0] from_secs(int t);
        return pack(t / 86400, (t / 3600) % 24, (t / 60) % 60, t % 60);
    endfunction

    // Driver side: queue an expectation and wait for the monitor to serve it.
    task automatic expect_val(input logic [7:0] a, input logic [31:0] e,
                              input string tag);
        item_t it;
        it.addr = a; it.exp = e; it.tag = tag;
        sbq.push_back(it);
        issued++;
        wait (served == issued);
    endtask

    // Monitor: pop expectations and compare against the read port or irq.
    initial begin
        forever begin
            item_t it;
            logic [31:0] act;
            wait (sbq.size() > 0);
            it = sbq.pop_front();
            rd_addr = it.addr;
            #1;
            act = (it.addr == A_PIN) ? {31'b0, irq} : rd_data;
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s addr=%h actual=%h expected=%h",
                         it.tag, it.addr, act, it.exp);
            end
            served++;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sec_tick = 1'b1;
            @(negedge clk); sec_tick = 1'b0;
        end
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        expect_val(A_CNT, 0, "R1 count");
        expect_val(A_RUN, 0, "R1 run");
        expect_val(A_MSK, 0, "R1 mask");
        expect_val(A_STS, 0, "R1 status");
        expect_val(A_PIN, 0, "R1 irq");

        // R2 layout and readback; bits outside fields read zero
        wr(A_CNT, pack(200, 21, 47, 33));
        expect_val(A_CNT, pack(200, 21, 47, 33), "R2 fields");
        wr(A_CNT, 32'hFFFF_FFFF);
        expect_val(A_CNT, 32'h1FFF_3F3F, "R2 spare bits zero");

        // R8 stopped: ticks do nothing
        wr(A_CNT, pack(1, 2, 3, 4));
        ticks(4);
        expect_val(A_CNT, pack(1, 2, 3, 4), "R8 stopped count");
        expect_val(A_STS, 0, "R8 stopped pending");

        // R3 running decrement
        wr(A_RUN, 32'h100);
        expect_val(A_RUN, 32'h100, "R3 run bit");
        m = to_secs(pack(1, 2, 3, 4));
        ticks(5); m -= 5;
        expect_val(A_CNT, from_secs(m), "R3 five ticks");
        repeat (6) @(negedge clk);
        expect_val(A_CNT, from_secs(m), "R3 no tick holds");

        // R4 borrow chains
        wr(A_CNT, pack(1, 0, 0, 0));
        ticks(1);
        expect_val(A_CNT, pack(0, 23, 59, 59), "R4 day borrow");
        wr(A_CNT, pack(0, 0, 1, 0));
        ticks(1);
        expect_val(A_CNT, pack(0, 0, 0, 59), "R4 minute borrow");
        wr(A_CNT, pack(0, 5, 0, 0));
        ticks(1);
        expect_val(A_CNT, pack(0, 4, 59, 59), "R4 hour borrow");

        // R5 firing, R7 masked
        wr(A_CNT, pack(0, 0, 0, 3));
        ticks(2);
        expect_val(A_STS, 0, "R5 not yet");
        ticks(1);
        expect_val(A_CNT, 0, "R5 reached zero");
        expect_val(A_STS, 1, "R5 pending set");
        expect_val(A_PIN, 0, "R7 masked irq");
        ticks(3);
        expect_val(A_CNT, 0, "R5 stays zero");
        wr(A_MSK, 32'h1);
        expect_val(A_PIN, 1, "R7 irq asserted");
        repeat (4) @(negedge clk);
        expect_val(A_PIN, 1, "R7 irq held");
        wr(A_STS, 32'h0);
        expect_val(A_STS, 1, "R6 write zero keeps");
        wr(A_MSK, 32'h0);
        expect_val(A_PIN, 0, "R7 mask drops irq");
        expect_val(A_STS, 1, "R7 mask keeps flag");
        wr(A_MSK, 32'h1);
        wr(A_STS, 32'h1);
        expect_val(A_STS, 0, "R6 w1c clears");
        expect_val(A_PIN, 0, "R6 irq after clear");

        // R9 reload while running; zero load never fires
        wr(A_CNT, pack(0, 0, 1, 40));
        ticks(2);
        expect_val(A_CNT, pack(0, 0, 1, 38), "R9 before reload");
        wr(A_CNT, pack(0, 0, 0, 5));
        expect_val(A_CNT, pack(0, 0, 0, 5), "R9 reload visible");
        wr(A_CNT, 0);
        ticks(4);
        expect_val(A_STS, 0, "R9 zero never fires");
        expect_val(A_PIN, 0, "R9 no irq");

        // R8 stop mid-count
        wr(A_CNT, pack(0, 0, 0, 2));
        wr(A_RUN, 0);
        ticks(5);
        expect_val(A_CNT, pack(0, 0, 0, 2), "R8 halted count");
        expect_val(A_STS, 0, "R8 halted no pending");

        // R3 long run across borrows to zero
        wr(A_CNT, pack(0, 1, 0, 2));
        wr(A_RUN, 32'h100);
        m = to_secs(pack(0, 1, 0, 2));
        ticks(1000); m -= 1000;
        expect_val(A_CNT, from_secs(m), "R3 long partial");
        ticks(m - 1);
        expect_val(A_STS, 0, "R5 one before zero");
        ticks(1);
        expect_val(A_CNT, 0, "R5 long zero");
        expect_val(A_PIN, 1, "R7 long irq");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule